// File: doc/BRIEF.md
# Event Timer Register Block

This block is the register front end of an event-timer unit built around a 32-bit free-running main counter. A simple request port carries reads and writes of 4 or 8 bytes against a map of 64-bit registers. The block itself owns a computed read-only capability word, a global configuration register whose bit 0 starts and stops the counter, and the main counter. It decodes accesses to the per-timer register windows and forwards them to the comparator blocks, which hold those registers.

A 4-byte access selects one half of a 64-bit register. Its offset bit 2 picks the half. Write data and the byte-lane mask are moved into that half, and only masked bits change. Read data for the upper half is moved down to bits 31:0. When counting starts, or when the counter is written while it runs, the block pulses a rearm strobe so that every comparator reloads against the new count.

The register map is fixed. The capability word is at 0x000, configuration at 0x010 and the main counter at 0x0F0. Timer n has a 32-byte window at 0x100 + 0x20·n, with its configuration at +0x00, its comparator at +0x08 and its interrupt route at +0x10.

Top module: `et_regblk`

## Requirements
- R1: An access whose size is neither 4 nor 8 bytes changes no state and is not forwarded. A read of that kind returns zero.
- R2: An access whose offset is not a multiple of its size changes no state and is not forwarded. A read of that kind returns zero.
- R3: A 4-byte access with offset bit 2 set works on bits 63:32. Its write data and mask are shifted up by 32 (mask 0xFFFFFFFF_00000000). Its read data is returned in bits 31:0 with bits 63:32 zero. A 4-byte access with bit 2 clear returns bits 31:0 and zero above them.
- R4: A write changes only the bits set in its mask: new = (old & ~mask) | (data & mask).
- R5: The capability word reads 0x038D7EA4 in bits 63:32, which is the tick period in femtoseconds (10^15 / 2^24, rounded down). It reads 0x8086 in bits 31:16, the timer count minus one in bits 12:8 and 0x01 in bits 7:0, with bit 13 clear to mark a 32-bit counter. Writes to it have no effect.
- R6: The configuration register resets to zero and keeps every written bit except bit 1 (legacy routing), which always reads zero. Bit 0 is the global enable.
- R7: While enabled, the counter rises by one at each clock with tick_en high and wraps modulo 2^32. While disabled it holds its value. When re-enabled it continues from the held value.
- R8: A counter write merges into the zero-extended count. Bits 63:32 always read zero, and a write to the upper half only leaves the count unchanged. A counter write wins over a tick in the same cycle.
- R9: rearm_all is high for exactly one cycle after a write that sets the enable from 0 to 1, and after a counter write while enabled. It is never high at any other time.
- R10: A legal access to timer n at window offset 0x00, 0x08 or 0x10 drives tmr_valid with tmr_index = n and tmr_reg = 0, 1 or 2, and drives the lane-aligned tmr_wdata and tmr_wmask. A read returns tmr_rdata through the R3 lane rule.
- R11: Offsets outside the map read zero and forward nothing. This covers the timer-window offset 0x18 and any window at or beyond the timer count.
- R12: rsp_valid is high in the cycle after each read request and low otherwise. rsp_rdata holds the registered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter tick enable pulse |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the register map |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, low-aligned |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 64 | Read response data |
| count_out | output | 32 | Main counter value |
| count_running | output | 1 | Global enable state |
| rearm_all | output | 1 | One-cycle strobe to reload all comparators |
| tmr_valid | output | 1 | Legal access to a timer window |
| tmr_write | output | 1 | The forwarded access is a write |
| tmr_index | output | 5 | Selected timer |
| tmr_reg | output | 2 | Register within the window: 0 config, 1 comparator, 2 route |
| tmr_wdata | output | 64 | Lane-aligned write data |
| tmr_wmask | output | 64 | Lane write mask |
| tmr_rdata | input | 64 | Read data from the selected timer register, valid in the request cycle |

## Verification
The cycle properties watch four things on every cycle: counter stepping and holding against the enable, the one-read-one-response pairing, the blocking of bad sizes, and the rule that rearm only appears while the counter runs. They also check that legacy routing never sets and that half-word forwards carry a 32-bit mask. Map decode, half-word merging into configuration and counter, the exact capability encoding, and the placement of rearm pulses relative to the enable edges can only be shown by the bench's access sequences. Wrap-around of the count is shown the same way.

// File: rtl/et_regs_pkg.sv
package et_regs_pkg;

    localparam int WORD_W   = 64;
    localparam int HALF_W   = 32;
    localparam int CNT_W    = 32;
    localparam int TIDX_W   = 5;
    localparam int MIN_TMR  = 3;
    localparam int MAX_TMR  = 32;

    // capability word fields
    localparam logic [15:0] CAPS_VENDOR   = 16'h8086;
    localparam logic [7:0]  CAPS_REV      = 8'h01;
    localparam int          CAPS_WIDE_BIT = 13;
    localparam longint unsigned FEMTO_PER_SEC = 64'd1000000000000000;
    localparam longint unsigned TICK_RATE_HZ  = 64'd16777216;

    // configuration bits
    localparam int CONF_EN_BIT     = 0;
    localparam int CONF_LEGACY_BIT = 1;

    // register map
    localparam int OFF_CAPS     = 'h000;
    localparam int OFF_CONF     = 'h010;
    localparam int OFF_COUNT    = 'h0F0;
    localparam int OFF_TMR_BASE = 'h100;
    localparam int TMR_STRIDE   = 'h20;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CAPS,
        TGT_CONF,
        TGT_COUNT,
        TGT_TMR
    } tgt_e;

    typedef enum logic [1:0] {
        TREG_CFG   = 2'd0,
        TREG_CMP   = 2'd1,
        TREG_ROUTE = 2'd2,
        TREG_NONE  = 2'd3
    } treg_e;

    typedef struct packed {
        logic               legal;
        logic               half;
        logic               upper;
        tgt_e               tgt;
        logic [TIDX_W-1:0]  tidx;
        treg_e              treg;
        logic [WORD_W-1:0]  wmask;
        logic [WORD_W-1:0]  wdata;
    } acc_t;

    function automatic logic [WORD_W-1:0] merge_bits(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [WORD_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [WORD_W-1:0] caps_word(input int unsigned ntmr);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[63:32]         = HALF_W'(FEMTO_PER_SEC / TICK_RATE_HZ);
        w[31:16]         = CAPS_VENDOR;
        w[12:8]          = 5'(ntmr - 1);
        w[CAPS_WIDE_BIT] = 1'b0;
        w[7:0]           = CAPS_REV;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] lane_read(
        input logic [WORD_W-1:0] v,
        input logic              half,
        input logic              upper
    );
        if (!half)
            return v;
        else if (upper)
            return {{HALF_W{1'b0}}, v[63:32]};
        else
            return {{HALF_W{1'b0}}, v[31:0]};
    endfunction

endpackage

// File: rtl/et_acc_decode.sv
module et_acc_decode
    import et_regs_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int NUM_TMR = 8
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output acc_t              acc
);

    localparam int WIN_SH = $clog2(TMR_STRIDE);
    localparam logic [ADDR_W-1:0] A_CAPS  = ADDR_W'(OFF_CAPS);
    localparam logic [ADDR_W-1:0] A_CONF  = ADDR_W'(OFF_CONF);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_TLO   = ADDR_W'(OFF_TMR_BASE);
    localparam logic [ADDR_W-1:0] A_THI   = ADDR_W'(OFF_TMR_BASE + TMR_STRIDE * NUM_TMR);

    logic              is_q;
    logic              is_h;
    logic              align_ok;
    logic [ADDR_W-1:0] qaddr;
    logic [ADDR_W-1:0] rel;
    logic [1:0]        sub;

    always_comb begin
        is_q     = (req_size == 4'd8);
        is_h     = (req_size == 4'd4);
        align_ok = is_q ? (req_addr[2:0] == 3'b000) : (req_addr[1:0] == 2'b00);
        qaddr    = {req_addr[ADDR_W-1:3], 3'b000};
        rel      = req_addr - A_TLO;
        sub      = rel[WIN_SH-1:3];

        acc       = '0;
        acc.legal = req_valid && (is_q || is_h) && align_ok;
        acc.half  = is_h;
        acc.upper = is_h && req_addr[2];
        acc.tgt   = TGT_NONE;
        acc.treg  = TREG_NONE;

        if (qaddr == A_CAPS) begin
            acc.tgt = TGT_CAPS;
        end else if (qaddr == A_CONF) begin
            acc.tgt = TGT_CONF;
        end else if (qaddr == A_COUNT) begin
            acc.tgt = TGT_COUNT;
        end else if (req_addr >= A_TLO && req_addr < A_THI) begin
            acc.tidx = TIDX_W'(rel >> WIN_SH);
            acc.treg = treg_e'(sub);
            if (sub != 2'b11)
                acc.tgt = TGT_TMR;
        end

        if (is_q) begin
            acc.wmask = '1;
            acc.wdata = req_wdata;
        end else if (acc.upper) begin
            acc.wmask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
            acc.wdata = {req_wdata[31:0], {HALF_W{1'b0}}};
        end else begin
            acc.wmask = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            acc.wdata = {{HALF_W{1'b0}}, req_wdata[31:0]};
        end
    end

endmodule

// File: rtl/et_main_counter.sv
module et_main_counter
    import et_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             en_q,
    input  logic             en_d,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] wr_mask,
    output logic [CNT_W-1:0] count,
    output logic             rearm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            rearm <= 1'b0;
        end else begin
            rearm <= (en_d && !en_q) || (cnt_wr && en_q);
            if (cnt_wr)
                count <= (count & ~wr_mask) | (wr_data & wr_mask);
            else if (en_q && tick_en)
                count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/et_read_mux.sv
module et_read_mux
    import et_regs_pkg::*;
#(
    parameter int NUM_TMR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              legal,
    input  logic              half,
    input  logic              upper,
    input  tgt_e              tgt,
    input  logic [WORD_W-1:0] cfg,
    input  logic [CNT_W-1:0]  count,
    input  logic [WORD_W-1:0] tmr_rdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata
);

    localparam logic [WORD_W-1:0] CAPS_VAL = caps_word(NUM_TMR);

    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] shaped;

    always_comb begin
        unique case (tgt)
            TGT_CAPS:  sel = CAPS_VAL;
            TGT_CONF:  sel = cfg;
            TGT_COUNT: sel = {{(WORD_W-CNT_W){1'b0}}, count};
            TGT_TMR:   sel = tmr_rdata;
            default:   sel = '0;
        endcase
        shaped = legal ? lane_read(sel, half, upper) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? shaped : '0;
        end
    end

endmodule

// File: rtl/et_regblk.sv
module et_regblk
    import et_regs_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int NUM_TMR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic [31:0]       count_out,
    output logic              count_running,
    output logic              rearm_all,
    output logic              tmr_valid,
    output logic              tmr_write,
    output logic [4:0]        tmr_index,
    output logic [1:0]        tmr_reg,
    output logic [63:0]       tmr_wdata,
    output logic [63:0]       tmr_wmask,
    input  logic [63:0]       tmr_rdata
);

    generate
        if (NUM_TMR < MIN_TMR || NUM_TMR > MAX_TMR) begin : g_bad_count
            $error("timer count out of range");
        end
    endgenerate

    acc_t              acc;
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] cfg_next;
    logic              wr_ok;
    logic              cfg_wr;
    logic              cnt_wr;
    logic              en_d;
    logic              rd_req;

    et_acc_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_TMR (NUM_TMR)
    ) u_dec (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .acc       (acc)
    );

    always_comb begin
        wr_ok    = acc.legal && req_write;
        cfg_wr   = wr_ok && (acc.tgt == TGT_CONF);
        cnt_wr   = wr_ok && (acc.tgt == TGT_COUNT);
        rd_req   = req_valid && !req_write;
        cfg_next = merge_bits(cfg_q, acc.wdata, acc.wmask);
        cfg_next[CONF_LEGACY_BIT] = 1'b0;
        en_d     = cfg_wr ? cfg_next[CONF_EN_BIT] : cfg_q[CONF_EN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_next;
    end

    et_main_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .en_q    (cfg_q[CONF_EN_BIT]),
        .en_d    (en_d),
        .cnt_wr  (cnt_wr),
        .wr_data (acc.wdata[CNT_W-1:0]),
        .wr_mask (acc.wmask[CNT_W-1:0]),
        .count   (count_out),
        .rearm   (rearm_all)
    );

    et_read_mux #(
        .NUM_TMR (NUM_TMR)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .legal     (acc.legal),
        .half      (acc.half),
        .upper     (acc.upper),
        .tgt       (acc.tgt),
        .cfg       (cfg_q),
        .count     (count_out),
        .tmr_rdata (tmr_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    always_comb begin
        count_running = cfg_q[CONF_EN_BIT];
        tmr_valid     = acc.legal && (acc.tgt == TGT_TMR);
        tmr_write     = req_write;
        tmr_index     = acc.tidx;
        tmr_reg       = acc.treg;
        tmr_wdata     = acc.wdata;
        tmr_wmask     = acc.wmask;
    end

endmodule

// File: rtl/et_regblk_chk.sv
module et_regblk_chk
    import et_regs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic [31:0]       count_out,
    input logic              count_running,
    input logic              rearm_all,
    input logic              rsp_valid,
    input logic [63:0]       rsp_rdata,
    input logic              tmr_valid,
    input logic              tmr_write,
    input logic [63:0]       tmr_wmask,
    input logic [63:0]       cfg_q
);

    logic cnt_touch;
    logic bad_size;

    always_comb begin
        cnt_touch = req_valid && req_write &&
                    ({req_addr[ADDR_W-1:3], 3'b000} == ADDR_W'(OFF_COUNT));
        bad_size  = (req_size != 4'd4) && (req_size != 4'd8);
    end

    assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        (!count_running && !cnt_touch) |=> $stable(count_out));

    assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
        (count_running && tick_en && !cnt_touch) |=> (count_out == $past(count_out) + 32'd1));

    assert_rsp_after_read_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_stray_rsp_R12: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_bad_size_blocked_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bad_size) |-> !tmr_valid);

    assert_bad_size_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && bad_size) |=> (rsp_rdata == 64'd0));

    assert_rearm_running_R9: assert property (@(posedge clk) disable iff (rst)
        rearm_all |-> count_running);

    assert_half_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (tmr_valid && tmr_write && req_size == 4'd4) |-> ($countones(tmr_wmask) == 32));

    assert_legacy_clear_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !cfg_q[CONF_LEGACY_BIT]);

endmodule

bind et_regblk et_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_en       (tick_en),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .count_out     (count_out),
    .count_running (count_running),
    .rearm_all     (rearm_all),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .tmr_valid     (tmr_valid),
    .tmr_write     (tmr_write),
    .tmr_wmask     (tmr_wmask),
    .cfg_q         (cfg_q)
);

// File: tb/et_regblk_bench.sv
`timescale 1ns/1ps
module et_regblk_bench;

    localparam int ADDR_W = 11;
    localparam int NV     = 32;

    typedef struct packed {
        logic        wr;
        logic [10:0] addr;
        logic [3:0]  size;
        logic [63:0] data;
        logic [63:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam logic [63:0] CAPS = 64'h038D7EA4_80860701;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 11'h000, 4'd8, 64'h0, CAPS, 8'd5},                                 // R5
        '{1'b0, 11'h004, 4'd4, 64'h0, 64'h00000000_038D7EA4, 8'd3},               // R3
        '{1'b0, 11'h000, 4'd4, 64'h0, 64'h00000000_80860701, 8'd5},               // R5
        '{1'b1, 11'h000, 4'd8, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 8'd5},               // R5
        '{1'b0, 11'h000, 4'd8, 64'h0, CAPS, 8'd5},                                 // R5
        '{1'b1, 11'h010, 4'd8, 64'hF0F00000_000000FE, 64'h0, 8'd6},               // R6
        '{1'b0, 11'h010, 4'd8, 64'h0, 64'hF0F00000_000000FC, 8'd6},               // R6
        '{1'b1, 11'h014, 4'd4, 64'h00000000_12345678, 64'h0, 8'd3},               // R3
        '{1'b0, 11'h010, 4'd8, 64'h0, 64'h12345678_000000FC, 8'd3},               // R3
        '{1'b1, 11'h010, 4'd4, 64'h00000000_AAAAAAAA, 64'h0, 8'd4},               // R4
        '{1'b0, 11'h010, 4'd8, 64'h0, 64'h12345678_AAAAAAA8, 8'd4},               // R4
        '{1'b0, 11'h014, 4'd4, 64'h0, 64'h00000000_12345678, 8'd3},               // R3
        '{1'b0, 11'h010, 4'd2, 64'h0, 64'h0, 8'd1},                                // R1
        '{1'b1, 11'h010, 4'd2, 64'h0, 64'h0, 8'd1},                                // R1
        '{1'b0, 11'h010, 4'd8, 64'h0, 64'h12345678_AAAAAAA8, 8'd1},               // R1
        '{1'b0, 11'h014, 4'd8, 64'h0, 64'h0, 8'd2},                                // R2
        '{1'b1, 11'h012, 4'd4, 64'h0, 64'h0, 8'd2},                                // R2
        '{1'b0, 11'h010, 4'd8, 64'h0, 64'h12345678_AAAAAAA8, 8'd2},               // R2
        '{1'b0, 11'h020, 4'd8, 64'h0, 64'h0, 8'd11},                               // R11
        '{1'b1, 11'h0F0, 4'd8, 64'hFFFFFFFF_12345678, 64'h0, 8'd8},               // R8
        '{1'b0, 11'h0F0, 4'd8, 64'h0, 64'h00000000_12345678, 8'd8},               // R8
        '{1'b1, 11'h0F4, 4'd4, 64'h00000000_0000DEAD, 64'h0, 8'd8},               // R8
        '{1'b0, 11'h0F0, 4'd8, 64'h0, 64'h00000000_12345678, 8'd8},               // R8
        '{1'b0, 11'h0F4, 4'd4, 64'h0, 64'h0, 8'd8},                                // R8
        '{1'b1, 11'h0F0, 4'd4, 64'h00000000_00000100, 64'h0, 8'd8},               // R8
        '{1'b0, 11'h0F0, 4'd8, 64'h0, 64'h00000000_00000100, 8'd8},               // R8
        '{1'b0, 11'h148, 4'd8, 64'h0, 64'hC0DE0201_BEEF0201, 8'd10},              // R10
        '{1'b0, 11'h14C, 4'd4, 64'h0, 64'h00000000_C0DE0201, 8'd10},              // R10
        '{1'b0, 11'h1F0, 4'd8, 64'h0, 64'hC0DE0702_BEEF0702, 8'd10},              // R10
        '{1'b0, 11'h200, 4'd8, 64'h0, 64'h0, 8'd11},                               // R11
        '{1'b0, 11'h118, 4'd8, 64'h0, 64'h0, 8'd11},                               // R11
        '{1'b0, 11'h108, 4'd3, 64'h0, 64'h0, 8'd1}                                 // R1
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = 4'd8;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic [31:0]       count_out;
    logic              count_running;
    logic              rearm_all;
    logic              tmr_valid;
    logic              tmr_write;
    logic [4:0]        tmr_index;
    logic [1:0]        tmr_reg;
    logic [63:0]       tmr_wdata;
    logic [63:0]       tmr_wmask;
    logic [63:0]       tmr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // snapshot of forwarded access, taken inside the request cycle
    logic        s_tv;
    logic [4:0]  s_ti;
    logic [1:0]  s_tr;
    logic [63:0] s_td;
    logic [63:0] s_tm;
    logic [63:0] r_data;
    logic        r_valid;
    logic        r_rearm;

    always #10 clk = ~clk;

    assign tmr_rdata = {16'hC0DE, 3'b000, tmr_index, 6'b000000, tmr_reg,
                        16'hBEEF, 3'b000, tmr_index, 6'b000000, tmr_reg};

    et_regblk #(.ADDR_W(ADDR_W), .NUM_TMR(8)) u_et_regblk (
        .clk (clk), .rst (rst), .tick_en (tick_en),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .count_out (count_out), .count_running (count_running), .rearm_all (rearm_all),
        .tmr_valid (tmr_valid), .tmr_write (tmr_write), .tmr_index (tmr_index),
        .tmr_reg (tmr_reg), .tmr_wdata (tmr_wdata), .tmr_wmask (tmr_wmask),
        .tmr_rdata (tmr_rdata)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = d;
        #1;
        s_tv = tmr_valid;
        s_ti = tmr_index;
        s_tr = tmr_reg;
        s_td = tmr_wdata;
        s_tm = tmr_wmask;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_data  = rsp_rdata;
        r_valid = rsp_valid;
        r_rearm = rearm_all;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R6, R7, R9, R12)
        check("R7 reset count", 64'(count_out), 64'h0);
        check("R7 reset running", 64'(count_running), 64'h0);
        check("R9 reset rearm", 64'(rearm_all), 64'h0);
        check("R12 reset rsp_valid", 64'(rsp_valid), 64'h0);
        access(1'b0, 11'h010, 4'd8, 64'h0);
        check("R6 reset config", r_data, 64'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].data);
            if (VEC[i].wr) begin
                check($sformatf("R12 no rsp on write vec %0d", i), 64'(r_valid), 64'h0);
            end else begin
                check($sformatf("R%0d read vec %0d", VEC[i].rq, i), r_data, VEC[i].exp);
                check($sformatf("R12 rsp on read vec %0d", i), 64'(r_valid), 64'h1);
            end
        end

        // forwarding to timer windows (R10, R3)
        access(1'b1, 11'h10C, 4'd4, 64'h55);
        check("R10 fwd valid", 64'(s_tv), 64'h1);
        check("R10 fwd index", 64'(s_ti), 64'h0);
        check("R10 fwd reg", 64'(s_tr), 64'h1);
        check("R3 fwd upper mask", s_tm, 64'hFFFFFFFF_00000000);
        check("R3 fwd upper data", s_td, 64'h00000055_00000000);
        access(1'b1, 11'h1E8, 4'd8, 64'h01234567_89ABCDEF);
        check("R10 fwd idx7", 64'(s_ti), 64'h7);
        check("R10 fwd full mask", s_tm, 64'hFFFFFFFF_FFFFFFFF);
        check("R10 fwd full data", s_td, 64'h01234567_89ABCDEF);
        access(1'b1, 11'h10A, 4'd4, 64'h1);
        check("R2 misaligned not forwarded", 64'(s_tv), 64'h0);
        access(1'b1, 11'h108, 4'd1, 64'h1);
        check("R1 byte size not forwarded", 64'(s_tv), 64'h0);
        access(1'b1, 11'h118, 4'd8, 64'h1);
        check("R11 gap not forwarded", 64'(s_tv), 64'h0);
        access(1'b1, 11'h200, 4'd8, 64'h1);
        check("R11 past last timer not forwarded", 64'(s_tv), 64'h0);

        // counter run/hold/rearm (R7, R8, R9); count is 0x100, disabled
        access(1'b1, 11'h010, 4'd4, 64'hAAAAAAA9);
        check("R9 rearm on enable", 64'(r_rearm), 64'h1);
        check("R7 running", 64'(count_running), 64'h1);
        @(negedge clk);
        check("R9 rearm one cycle", 64'(rearm_all), 64'h0);
        ticks(5);
        check("R7 five ticks", 64'(count_out), 64'h105);
        access(1'b0, 11'h0F0, 4'd8, 64'h0);
        check("R7 counter read", r_data, 64'h105);
        access(1'b0, 11'h010, 4'd8, 64'h0);
        check("R6 enable stored", r_data, 64'h12345678_AAAAAAA9);
        access(1'b1, 11'h010, 4'd4, 64'hAAAAAAA8);
        check("R9 no rearm on disable", 64'(r_rearm), 64'h0);
        ticks(3);
        check("R7 hold while disabled", 64'(count_out), 64'h105);
        access(1'b1, 11'h0F0, 4'd8, 64'hFFFFFFFE);
        check("R9 no rearm write disabled", 64'(r_rearm), 64'h0);
        check("R8 write disabled", 64'(count_out), 64'hFFFFFFFE);
        access(1'b1, 11'h010, 4'd4, 64'hAAAAAAA9);
        check("R9 rearm re-enable", 64'(r_rearm), 64'h1);
        ticks(3);
        check("R7 wrap", 64'(count_out), 64'h1);
        access(1'b1, 11'h0F0, 4'd4, 64'h40);
        check("R9 rearm write enabled", 64'(r_rearm), 64'h1);
        check("R8 write enabled", 64'(count_out), 64'h40);
        @(negedge clk);
        check("R9 rearm ends", 64'(rearm_all), 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule